// File: doc/BRIEF.md
# Halfword Byte-Swap DMA Bridge

This bridge connects the DMA side of a 16-bit network controller to a 32-bit byte-strobed memory port. The controller hands over one request at a time. A request carries a start address, a byte count, a direction and a bypass flag. The bridge then moves the data as a series of memory beats. Each beat moves one 16-bit item of the controller's data stream.

The bridge owns a high-address register. Its value is ORed into every request address, so the controller can reach memory above its own address range. In normal (swapped) mode:

- the address and the length are rounded down to whole halfwords;
- the two bytes of every halfword are exchanged in both directions;
- writes to memory are cut into bursts of at most 64 bytes.

In bypass mode the data keeps its byte order and the address and length are used as given. Odd addresses or an odd tail are then moved one byte per beat.

The memory side is a beat interface with valid/ready. Read data is returned combinationally in the cycle the beat is accepted, and is forwarded at once on the read stream. A one-cycle done pulse marks the end of every request, including an empty one.

Top module: `hsb_bridge`

## Requirements
- R1: The address of the first memory beat is the request address ORed with the high-address register, which is loaded from `cfg_hi_val` when `cfg_hi_we` is 1.
- R2: With `req_bypass`=0, bit 0 of the formed address and of the length are cleared before the transfer starts, so an odd length of 7 moves 6 bytes in 3 beats.
- R3: With `req_bypass`=0, the two bytes of each halfword are exchanged on both paths.
  - Write: the byte at the even address is `wr_data[15:8]` and the byte at the odd address is `wr_data[7:0]`.
  - Read: `rd_data[15:8]` is the byte at the even address.
- R4: With `req_bypass`=1, bytes are not exchanged.
  - A beat moves two bytes when its address is even and at least two bytes remain; the byte at the even address is in bits [7:0] of the stream item.
  - Otherwise a beat moves one byte, carried in bits [7:0]. On the read path bits [15:8] are then 0.
- R5: A byte at address A travels on memory lane A[1:0], meaning bits [8*A[1:0]+7 : 8*A[1:0]] of `mem_wdata`/`mem_rdata`. `mem_strb` has exactly the bits of the lanes moved set. `mem_write` is 1 for writes to memory.
- R6: In swapped mode, writes raise `mem_last` on the beat that completes every 64 bytes of the transfer and on the final beat. Reads and bypass writes raise `mem_last` only on the final beat.
- R7: `req_ready` is 0 from the acceptance of a non-empty request until it completes. `done` is high for one cycle, in the cycle after the final memory beat is accepted.
- R8: A request whose length is zero after rounding produces no memory beat and raises `done` in the cycle after acceptance.
- R9: After reset `req_ready` is 1, and `mem_valid` and `done` are 0.
- R10: Each memory beat's address is the previous beat's address plus the bytes that beat moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hi_we | input | 1 | Load the high-address register |
| cfg_hi_val | input | AW | Value for the high-address register |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle, request may be taken |
| req_addr | input | AW | Request byte address |
| req_len | input | LW | Request byte count |
| req_write | input | 1 | 1: controller data to memory, 0: memory to controller |
| req_bypass | input | 1 | 1: no byte exchange and no alignment |
| wr_valid | input | 1 | Write stream item present |
| wr_ready | output | 1 | Write stream item taken |
| wr_data | input | 16 | Write stream item |
| rd_valid | output | 1 | Read stream item present |
| rd_ready | input | 1 | Read stream sink can accept |
| rd_data | output | 16 | Read stream item |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Beat direction, 1 = write |
| mem_addr | output | AW | Byte address of the beat |
| mem_strb | output | 4 | Byte lanes used by the beat |
| mem_wdata | output | 32 | Write data, lanes replicated |
| mem_last | output | 1 | Last beat of a burst |
| mem_rdata | input | 32 | Read data, valid while the beat is accepted |
| done | output | 1 | One-cycle pulse at request completion |

## Verification
Swapped writes at a word-aligned address, and at an odd address with an odd length, separate correct lane placement and byte exchange from correct rounding. A swapped read, issued after the high-address register is loaded, shows the OR of the address and the exchange on the read path. Bypass transfers that start on an odd address and end on an odd byte force the single-byte steps. They tell unswapped placement apart from swapped placement. A 150-byte swapped write shows the burst cuts at 64 and 128 bytes, while long bypass writes and reads must show none. Zero-length and one-byte swapped requests show that empty requests end at once with no memory traffic. Random stalls on the memory, write and read streams run throughout.

// File: rtl/hsb_pkg.sv
`timescale 1ns/1ps
package hsb_pkg;

  // exchange the two bytes of a halfword
  function automatic logic [15:0] swap_half(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

  // one step moves a byte pair unless bypass leaves an odd address or one byte
  function automatic logic pair_step(input logic addr_odd, input logic two_left,
                                     input logic bypass);
    return bypass ? (!addr_odd && two_left) : 1'b1;
  endfunction

  // byte lanes touched by a step starting at word offset off
  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic pair);
    return pair ? (4'b0011 << off) : (4'b0001 << off);
  endfunction

  // byte on lane off of a 32-bit word
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] off);
    return w[8*off +: 8];
  endfunction

endpackage

// File: rtl/hsb_seq.sv
`timescale 1ns/1ps
module hsb_seq #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic          start_wr,
  input  logic          start_byp,
  input  logic          step,
  output logic          busy,
  output logic          wr_dir,
  output logic          bypass,
  output logic [AW-1:0] cur_addr,
  output logic          pair,
  output logic          burst_end,
  output logic          done
);
  localparam int CW = $clog2(CHUNK_BYTES + 1);

  logic [LW-1:0] rem_q;
  logic [CW-1:0] chunk_q;
  logic [1:0]    step_sz;
  logic          final_step;
  logic          chunk_full;
  logic          chunked;
  logic [CW:0]   chunk_next;

  assign pair       = hsb_pkg::pair_step(cur_addr[0], rem_q >= LW'(2), bypass);
  assign step_sz    = pair ? 2'd2 : 2'd1;
  assign final_step = (rem_q == LW'(step_sz));
  assign chunked    = wr_dir && !bypass;
  assign chunk_next = {1'b0, chunk_q} + (CW+1)'(step_sz);
  assign chunk_full = chunked && (chunk_next == (CW+1)'(CHUNK_BYTES));
  assign burst_end  = final_step || chunk_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wr_dir   <= 1'b0;
      bypass   <= 1'b0;
      cur_addr <= '0;
      rem_q    <= '0;
      chunk_q  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        if (start_len == '0) begin
          done <= 1'b1;
        end else begin
          busy     <= 1'b1;
          cur_addr <= start_addr;
          rem_q    <= start_len;
          wr_dir   <= start_wr;
          bypass   <= start_byp;
          chunk_q  <= '0;
        end
      end else if (step && busy) begin
        cur_addr <= cur_addr + AW'(step_sz);
        rem_q    <= rem_q - LW'(step_sz);
        if (chunked) chunk_q <= chunk_full ? '0 : chunk_next[CW-1:0];
        if (final_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && busy) |=> (cur_addr == $past(cur_addr) + AW'($past(step_sz))));

  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_q < CW'(CHUNK_BYTES));

  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && busy && final_step) |=> (done && !busy));

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_len == '0) |=> (done && !busy));

endmodule

// File: rtl/hsb_lanes.sv
`timescale 1ns/1ps
module hsb_lanes (
  input  logic        bypass,
  input  logic        pair,
  input  logic [1:0]  off,
  input  logic [15:0] wr_half,
  input  logic [31:0] rdata,
  output logic [31:0] wdata,
  output logic [3:0]  strb,
  output logic [15:0] rd_half
);
  logic [15:0] mem_order;
  logic [7:0]  lo_b;
  logic [7:0]  hi_b;

  // mem_order[7:0] belongs at the lower address
  assign mem_order = bypass ? wr_half : hsb_pkg::swap_half(wr_half);
  assign wdata     = pair ? {2{mem_order}} : {4{mem_order[7:0]}};
  assign strb      = hsb_pkg::lane_mask(off, pair);

  assign lo_b    = hsb_pkg::pick_byte(rdata, off);
  assign hi_b    = hsb_pkg::pick_byte(rdata, off + 2'd1);
  assign rd_half = !pair  ? {8'h00, lo_b} :
                   bypass ? {hi_b, lo_b}  : {lo_b, hi_b};

  // R4
  always_comb begin
    if (!pair) byte_step_chk: assert (!(rd_half[15:8] != 8'h00));
  end

endmodule

// File: rtl/hsb_bridge.sv
`timescale 1ns/1ps
module hsb_bridge #(
  parameter int AW          = 32,
  parameter int LW          = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_hi_we,
  input  logic [AW-1:0] cfg_hi_val,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic          req_bypass,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [15:0]   wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [15:0]   rd_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_strb,
  output logic [31:0]   mem_wdata,
  output logic          mem_last,
  input  logic [31:0]   mem_rdata,
  output logic          done
);
  logic [AW-1:0] hi_q;
  logic [AW-1:0] formed_addr;
  logic [AW-1:0] start_addr;
  logic [LW-1:0] start_len;
  logic          accept;
  logic          beat_fire;
  logic          busy;
  logic          wr_dir;
  logic          bypass;
  logic          pair;
  logic          burst_end;
  logic [AW-1:0] cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)         hi_q <= '0;
    else if (cfg_hi_we) hi_q <= cfg_hi_val;
  end

  assign formed_addr = req_addr | hi_q;
  assign start_addr  = req_bypass ? formed_addr : {formed_addr[AW-1:1], 1'b0};
  assign start_len   = req_bypass ? req_len     : {req_len[LW-1:1], 1'b0};

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  assign mem_valid = busy && (wr_dir ? wr_valid : rd_ready);
  assign beat_fire = mem_valid && mem_ready;
  assign wr_ready  = busy && wr_dir && mem_ready;
  assign rd_valid  = beat_fire && !wr_dir;
  assign mem_write = wr_dir;
  assign mem_addr  = cur_addr;
  assign mem_last  = burst_end;

  hsb_seq #(.AW(AW), .LW(LW), .CHUNK_BYTES(CHUNK_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (start_addr),
    .start_len  (start_len),
    .start_wr   (req_write),
    .start_byp  (req_bypass),
    .step       (beat_fire),
    .busy       (busy),
    .wr_dir     (wr_dir),
    .bypass     (bypass),
    .cur_addr   (cur_addr),
    .pair       (pair),
    .burst_end  (burst_end),
    .done       (done)
  );

  hsb_lanes u_lanes (
    .bypass  (bypass),
    .pair    (pair),
    .off     (cur_addr[1:0]),
    .wr_half (wr_data),
    .rdata   (mem_rdata),
    .wdata   (mem_wdata),
    .strb    (mem_strb),
    .rd_half (rd_data)
  );

  // R2
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !bypass) |-> (mem_addr[0] == 1'b0 && $countones(mem_strb) == 2));

  // R4
  odd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && bypass && mem_addr[0]) |-> ($countones(mem_strb) == 1));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_len >= LW'(2)) |=> !req_ready);

endmodule

// File: tb/hsb_bridge_test.sv
`timescale 1ns/1ps
module hsb_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_hi_we;
  logic [31:0] cfg_hi_val;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        req_write;
  logic        req_bypass;
  logic        wr_valid;
  logic        wr_ready;
  logic [15:0] wr_data;
  logic        rd_valid;
  logic        rd_ready;
  logic [15:0] rd_data;
  logic        mem_valid;
  logic        mem_ready;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_strb;
  logic [31:0] mem_wdata;
  logic        mem_last;
  logic [31:0] mem_rdata;
  logic        done;

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic [31:0] wd;
    logic [15:0] rd;
    logic        last;
    logic        wr;
    logic        byp;
    logic        fin;
  } beat_t;

  beat_t       exp_q[$];
  logic [15:0] src_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;
  int          dseed = 0;
  logic [31:0] hi_model = 32'h0;
  logic        exp_done_next = 1'b0;
  logic [7:0]  lf = 8'h5B;

  function automatic logic [31:0] pat(input logic [29:0] w);
    return {w[13:0], 2'b01, ~w[15:0]} ^ 32'h5A3C_96E1;
  endfunction

  assign mem_rdata = pat(mem_addr[31:2]);

  hsb_bridge uut (
    .clk(clk), .rst_n(rst_n), .cfg_hi_we(cfg_hi_we), .cfg_hi_val(cfg_hi_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_bypass(req_bypass),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_strb(mem_strb), .mem_wdata(mem_wdata),
    .mem_last(mem_last), .mem_rdata(mem_rdata), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // stall patterns on the memory and read sides
  always begin
    @(posedge clk);
    #1;
    lf        = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    mem_ready = lf[0] | lf[2];
    rd_ready  = lf[1] | lf[4];
  end

  // write-stream source
  always begin
    logic took;
    int   gap;
    gap = 0;
    forever begin
      @(negedge clk);
      took = wr_valid && wr_ready;
      @(posedge clk);
      #1;
      if (took && src_q.size() > 0) void'(src_q.pop_front());
      gap++;
      if (src_q.size() > 0 && (gap % 4) != 3) begin
        wr_valid = 1'b1;
        wr_data  = src_q[0];
      end else begin
        wr_valid = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (exp_done_next) begin
        chk(done === 1'b1, "R7", "done one cycle after final beat", {31'd0, done}, 32'd1);
        exp_done_next = 1'b0;
      end
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "memory beat with nothing expected", mem_addr, 32'h0);
        end else begin
          beat_t e;
          logic [31:0] m;
          e = exp_q.pop_front();
          m = {{8{e.strb[3]}}, {8{e.strb[2]}}, {8{e.strb[1]}}, {8{e.strb[0]}}};
          chk(mem_addr == e.addr, "R1", "beat address (R10 stepping)", mem_addr, e.addr);
          chk(mem_strb == e.strb, "R5", "byte strobes", {28'd0, mem_strb}, {28'd0, e.strb});
          chk(mem_write == e.wr, "R5", "beat direction", {31'd0, mem_write}, {31'd0, e.wr});
          chk(mem_last == e.last, "R6", "burst end flag", {31'd0, mem_last}, {31'd0, e.last});
          if (e.wr) begin
            chk((mem_wdata & m) == e.wd, e.byp ? "R4" : "R3", "write lane data",
                mem_wdata & m, e.wd);
          end else begin
            chk(rd_valid && rd_data == e.rd, e.byp ? "R4" : "R3", "read stream data",
                {15'd0, rd_valid, rd_data}, {16'd1, e.rd});
          end
          if (e.fin) exp_done_next = 1'b1;
        end
      end
    end
  end

  task automatic set_hi(input logic [31:0] v);
    @(posedge clk);
    #1;
    cfg_hi_we  = 1'b1;
    cfg_hi_val = v;
    @(posedge clk);
    #1;
    cfg_hi_we  = 1'b0;
    hi_model   = v;
  endtask

  task automatic xfer(input logic [31:0] a, input logic [15:0] len,
                      input bit wr, input bit byp, input string tag);
    logic [31:0] cur;
    int          rem;
    int          burst;
    int          t;
    bit          empty;
    cur = a | hi_model;
    rem = int'(len);
    if (!byp) begin
      cur[0] = 1'b0;
      rem    = rem & ~1;
    end
    empty = (rem == 0);
    burst = 0;
    while (rem > 0) begin
      beat_t       e;
      int          n;
      logic [15:0] d;
      logic [7:0]  b0;
      logic [7:0]  b1;
      logic [31:0] w;
      logic [7:0]  r0;
      logic [7:0]  r1;
      n  = (!cur[0] && rem >= 2) ? 2 : 1;
      d  = {dseed[7:0] ^ 8'hC3, dseed[7:0] + 8'h11};
      dseed++;
      b0 = byp ? d[7:0]  : d[15:8];
      b1 = byp ? d[15:8] : d[7:0];
      e.wd   = 32'h0;
      e.strb = 4'h0;
      for (int k = 0; k < n; k++) begin
        int ln;
        ln = (int'(cur[1:0]) + k) % 4;
        e.strb[ln] = 1'b1;
        e.wd[ln*8 +: 8] = (k == 0) ? b0 : b1;
      end
      w  = pat(cur[31:2]);
      r0 = w[int'(cur[1:0])*8 +: 8];
      r1 = w[((int'(cur[1:0]) + 1) % 4)*8 +: 8];
      e.rd   = (n == 1) ? {8'h00, r0} : (byp ? {r1, r0} : {r0, r1});
      e.addr = cur;
      e.wr   = wr;
      e.byp  = byp;
      e.fin  = (rem == n);
      if (wr && !byp && burst + n == 64) begin
        e.last = 1'b1;
        burst  = 0;
      end else begin
        e.last = (rem == n);
        burst  = burst + n;
      end
      exp_q.push_back(e);
      if (wr) src_q.push_back(byp && n == 1 ? {8'h00, d[7:0]} : d);
      cur = cur + 32'(n);
      rem = rem - n;
    end
    @(posedge clk);
    #1;
    req_valid  = 1'b1;
    req_addr   = a;
    req_len    = len;
    req_write  = wr;
    req_bypass = byp;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    t = 0;
    @(negedge clk);
    if (!empty) chk(req_ready == 1'b0, "R7", "no acceptance while busy", {31'd0, req_ready}, 32'd0);
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, empty ? "R8" : "R7", {tag, " completion seen"}, t, 0);
    chk(exp_q.size() == 0, empty ? "R8" : "R7", {tag, " all beats before done"},
        exp_q.size(), 0);
    repeat (2) @(posedge clk);
  endtask

  always begin
    @(posedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    cfg_hi_we  = 1'b0;
    cfg_hi_val = 32'h0;
    req_valid  = 1'b0;
    req_addr   = 32'h0;
    req_len    = 16'h0;
    req_write  = 1'b0;
    req_bypass = 1'b0;
    wr_valid   = 1'b0;
    wr_data    = 16'h0;
    mem_ready  = 1'b0;
    rd_ready   = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9
    chk(req_ready == 1'b1, "R9", "req_ready in reset", {31'd0, req_ready}, 32'd1);
    chk(mem_valid == 1'b0, "R9", "mem_valid in reset", {31'd0, mem_valid}, 32'd0);
    chk(done == 1'b0, "R9", "done in reset", {31'd0, done}, 32'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    xfer(32'h0000_0100, 16'd8,   1'b1, 1'b0, "R3 aligned swapped write");
    xfer(32'h0000_0103, 16'd7,   1'b1, 1'b0, "R2 odd address and length");
    set_hi(32'h0040_0000);
    xfer(32'h0000_0022, 16'd10,  1'b0, 1'b0, "R1 high-address swapped read");
    xfer(32'h0000_1000, 16'd150, 1'b1, 1'b0, "R6 chunked write");
    xfer(32'h0000_0201, 16'd7,   1'b1, 1'b1, "R4 bypass odd write");
    xfer(32'h0000_0305, 16'd6,   1'b0, 1'b1, "R4 bypass odd read");
    xfer(32'h0000_0400, 16'd100, 1'b1, 1'b1, "R6 unchunked bypass write");
    xfer(32'h0000_0600, 16'd140, 1'b0, 1'b0, "R6 unchunked read");
    xfer(32'h0000_0700, 16'd0,   1'b1, 1'b0, "R8 zero length");
    xfer(32'h0000_0701, 16'd1,   1'b0, 1'b0, "R8 rounded to zero");
    xfer(32'h0000_0801, 16'd1,   1'b0, 1'b1, "R4 single bypass byte");

    repeat (4) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule